// File: doc/BRIEF.md
# Pin Function Multiplexer with Glitch-Filtered Inputs

This block sits between a bank of pads and the logic that uses them. For each pin it chooses between plain general-purpose I/O, where a direction bit and a data-out bit set the pad and the pin level is read back, and a peripheral function, where a peripheral drives the pad directly and gets the pad level back. Every pin comes out of reset as a general-purpose input with its driver off.

Each pad input first passes through a two-flop synchronizer. Pins chosen at build time then pass through a glitch filter. The filter takes a sample on a strobe made from the clock by a programmable divider. It accepts a new level only after that level has been seen on a programmed number of strobes in a row. A count of zero turns the filter off. Software sets the mode, direction, data-out, filter count and divider through a small write-only register port.

Top module: `pinmux_qual_bank`

## Requirements
- R1: After reset every pin is in general-purpose mode as an input: `pad_oe`, `pad_out`, `gpio_din` and `periph_in` are all zero.
- R2: A pin in general-purpose mode (mode bit 0) has `pad_oe` equal to its direction bit (1 = output) and `pad_out` equal to its data-out bit.
- R3: A pin in peripheral mode (mode bit 1) has `pad_oe` and `pad_out` follow `periph_oe` and `periph_out` in the same cycle.
- R4: `gpio_din` always carries the conditioned pin level. `periph_in` carries it for pins in peripheral mode and is 0 for pins in general-purpose mode.
- R5: A write with `wr_en` high sets the register chosen by `wr_addr` at that clock edge: 0 mode, 1 direction, 2 data-out, 3 filter count (bits 3:0), 4 divider (bits 7:0). Writes to addresses 5 to 7 change nothing.
- R6: With a filter count of 0, a pad level reaches `gpio_din` on the third rising edge after it is applied. A one-clock pulse appears for exactly one clock.
- R7: With a filter count N greater than 0, a level that lasts for fewer than N consecutive samples never changes `gpio_din`.
- R8: With divider 0 and count N, a level held steady changes `gpio_din` on the (N+2)th rising edge after it is applied.
- R9: The sample strobe fires once every divider+1 clocks. With divider D, a held level needs N samples, which is N×(D+1) clocks, give or take one strobe period.
- R10: Any write to the filter count register clears the progress of every filter, so a run of matching samples in progress must start again.
- R11: Pins whose bit in the parameter `QUAL_PINS` is 0 are never filtered. With the default of 16'h00FF these are pins 8 to 15, and they act as in R6 whatever the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 16 | Write data |
| pad_in | input | 16 | Pad input levels (asynchronous) |
| pad_out | output | 16 | Pad output levels |
| pad_oe | output | 16 | Pad driver enables |
| periph_out | input | 16 | Peripheral output levels |
| periph_oe | input | 16 | Peripheral driver enables |
| periph_in | output | 16 | Conditioned pin levels to the peripheral |
| gpio_din | output | 16 | Conditioned pin levels for general-purpose reads |

## Verification
The bench pushes the filter to its exact edge. A pulse one sample shorter than the count must be dropped, and a level held for exactly the count must be taken on a known cycle. A filter that is off by one in its run compare fails one of these two checks. Other directed tests look for wrong behaviour elsewhere: the divider is checked by bounding when a held level may appear, so a strobe that fires every clock or too seldom shows up. Repeated writes to the count register must keep a held level from ever being accepted, which catches a filter that keeps its progress across a write. Other checks look at the unfiltered pins, the three-cycle bypass latency, the switch between modes within the same cycle, writes that land one edge late, and writes to unmapped addresses that alter state.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] REG_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] REG_DIR  = 3'd1;
    localparam logic [ADDR_W-1:0] REG_DOUT = 3'd2;
    localparam logic [ADDR_W-1:0] REG_QCNT = 3'd3;
    localparam logic [ADDR_W-1:0] REG_QDIV = 3'd4;
endpackage

// File: rtl/pinmux_cfg.sv
module pinmux_cfg #(
    parameter int NPINS = 16,
    parameter int CNTW  = 4,
    parameter int DIVW  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [pinmux_pkg::ADDR_W-1:0]  wr_addr,
    input  logic [NPINS-1:0]               wr_data,
    output logic [NPINS-1:0]               mode_o,
    output logic [NPINS-1:0]               dir_o,
    output logic [NPINS-1:0]               dout_o,
    output logic [CNTW-1:0]                qcnt_o,
    output logic [DIVW-1:0]                qdiv_o,
    output logic                           qclr_o
);
    import pinmux_pkg::*;

    typedef struct packed {
        logic [NPINS-1:0] mode;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] dout;
        logic [CNTW-1:0]  qcnt;
        logic [DIVW-1:0]  qdiv;
        logic             clr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d     = cfg_q;
        cfg_d.clr = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                REG_MODE: cfg_d.mode = wr_data;
                REG_DIR:  cfg_d.dir  = wr_data;
                REG_DOUT: cfg_d.dout = wr_data;
                REG_QCNT: begin
                    cfg_d.qcnt = wr_data[CNTW-1:0];
                    cfg_d.clr  = 1'b1;
                end
                REG_QDIV: cfg_d.qdiv = wr_data[DIVW-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign mode_o = cfg_q.mode;
    assign dir_o  = cfg_q.dir;
    assign dout_o = cfg_q.dout;
    assign qcnt_o = cfg_q.qcnt;
    assign qdiv_o = cfg_q.qdiv;
    assign qclr_o = cfg_q.clr;

    // R5: writes to unmapped addresses leave every register untouched
    a_r5_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > REG_QDIV) |=>
            ($stable(mode_o) && $stable(dir_o) && $stable(dout_o) &&
             $stable(qcnt_o) && $stable(qdiv_o)));

    // R10: the filter clear pulse lasts one cycle and follows a count write
    a_r10_clear_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        qclr_o |-> $past(wr_en && wr_addr == REG_QCNT));
endmodule

// File: rtl/pinmux_strobe.sv
module pinmux_strobe #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DIVW-1:0] div_i,
    output logic            strobe_o
);
    typedef struct packed {
        logic [DIVW-1:0] cnt;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        strobe_o = (div_q.cnt >= div_i);
        div_d    = div_q;
        if (strobe_o) div_d.cnt = '0;
        else          div_d.cnt = div_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R9: with a non-zero divider, two strobes never come back to back
    a_r9_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o && div_i != '0) |=> (!strobe_o || div_i == '0));
endmodule

// File: rtl/pinmux_qual.sv
module pinmux_qual #(
    parameter int CNTW    = 4,
    parameter bit QUAL_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pin_i,
    input  logic            strobe_i,
    input  logic [CNTW-1:0] qcnt_i,
    input  logic            clr_i,
    output logic            qual_o
);
    typedef struct packed {
        logic            sync1;
        logic            sync2;
        logic            qual;
        logic [CNTW-1:0] run;
    } flt_t;

    flt_t flt_d, flt_q;
    logic            bypass;
    logic [CNTW:0]   run_nx;

    assign bypass = !QUAL_EN || (qcnt_i == '0);
    assign run_nx = {1'b0, flt_q.run} + {{CNTW{1'b0}}, 1'b1};

    always_comb begin
        flt_d       = flt_q;
        flt_d.sync1 = pin_i;
        flt_d.sync2 = flt_q.sync1;
        if (bypass) begin
            flt_d.qual = flt_q.sync2;
            flt_d.run  = '0;
        end else if (clr_i) begin
            flt_d.run  = '0;
        end else if (strobe_i) begin
            if (flt_q.sync2 != flt_q.qual) begin
                if (run_nx >= {1'b0, qcnt_i}) begin
                    flt_d.qual = flt_q.sync2;
                    flt_d.run  = '0;
                end else begin
                    flt_d.run  = run_nx[CNTW-1:0];
                end
            end else begin
                flt_d.run = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign qual_o = flt_q.qual;

    // R6: with the filter off, the output is the synchronized level one clock later
    a_r6_bypass_follow: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> (qual_o == $past(flt_q.sync2)));

    // R7: an active filter changes its output only on a strobe
    a_r7_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !strobe_i) |=> $stable(qual_o));

    // R10: a clear cycle never moves the output
    a_r10_clear_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && clr_i) |=> $stable(qual_o));
endmodule

// File: rtl/pinmux_qual_bank.sv
module pinmux_qual_bank #(
    parameter int               NPINS     = 16,
    parameter int               CNTW      = 4,
    parameter int               DIVW      = 8,
    parameter logic [NPINS-1:0] QUAL_PINS = 16'h00FF
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [pinmux_pkg::ADDR_W-1:0] wr_addr,
    input  logic [NPINS-1:0]              wr_data,
    input  logic [NPINS-1:0]              pad_in,
    output logic [NPINS-1:0]              pad_out,
    output logic [NPINS-1:0]              pad_oe,
    input  logic [NPINS-1:0]              periph_out,
    input  logic [NPINS-1:0]              periph_oe,
    output logic [NPINS-1:0]              periph_in,
    output logic [NPINS-1:0]              gpio_din
);
    logic [NPINS-1:0] mode_q, dir_q, dout_q, qual;
    logic [CNTW-1:0]  qcnt_q;
    logic [DIVW-1:0]  qdiv_q;
    logic             qclr_q;
    logic             strobe;

    pinmux_cfg #(.NPINS(NPINS), .CNTW(CNTW), .DIVW(DIVW)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .mode_o  (mode_q),
        .dir_o   (dir_q),
        .dout_o  (dout_q),
        .qcnt_o  (qcnt_q),
        .qdiv_o  (qdiv_q),
        .qclr_o  (qclr_q)
    );

    pinmux_strobe #(.DIVW(DIVW)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_i    (qdiv_q),
        .strobe_o (strobe)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pinmux_qual #(.CNTW(CNTW), .QUAL_EN(QUAL_PINS[i])) u_qual (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_i    (pad_in[i]),
            .strobe_i (strobe),
            .qcnt_i   (qcnt_q),
            .clr_i    (qclr_q),
            .qual_o   (qual[i])
        );

        always_comb begin
            if (mode_q[i]) begin
                pad_oe[i]    = periph_oe[i];
                pad_out[i]   = periph_out[i];
                periph_in[i] = qual[i];
            end else begin
                pad_oe[i]    = dir_q[i];
                pad_out[i]   = dout_q[i];
                periph_in[i] = 1'b0;
            end
        end

        // R4: a pin in general-purpose mode hands nothing to the peripheral
        a_r4_periph_in_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !mode_q[i] |-> !periph_in[i]);
    end

    assign gpio_din = qual;

    // R1: the first cycle after reset has every driver off
    a_r1_drivers_off: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pad_oe == '0 && gpio_din == '0));
endmodule

// File: tb/test_pinmux_qual_bank.sv
module test_pinmux_qual_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] pad_in = '0;
    logic [15:0] periph_out = '0;
    logic [15:0] periph_oe = '0;
    logic [15:0] pad_out, pad_oe, periph_in, gpio_din;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pinmux_qual_bank i_pinmux_qual_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .pad_in     (pad_in),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .periph_out (periph_out),
        .periph_oe  (periph_oe),
        .periph_in  (periph_in),
        .gpio_din   (gpio_din)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clocks(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 pad_oe", pad_oe, 16'h0000);
        check("R1 pad_out", pad_out, 16'h0000);
        check("R1 gpio_din", gpio_din, 16'h0000);
        check("R1 periph_in", periph_in, 16'h0000);
    endtask

    task automatic t_gpio;
        wr(3'd1, 16'hF0F0);
        wr(3'd2, 16'hAAAA);
        check("R2 pad_oe", pad_oe, 16'hF0F0);
        check("R2 pad_out", pad_out, 16'hAAAA);
    endtask

    task automatic t_periph;
        periph_out = 16'h1234; periph_oe = 16'h00FF;
        wr(3'd0, 16'h00FF);
        check("R3 pad_oe", pad_oe, 16'hF0FF);
        check("R3 pad_out", pad_out, 16'hAA34);
        periph_oe = 16'h0000; periph_out = 16'h0000;
        #1;
        check("R3 same-cycle oe", pad_oe, 16'hF000);
        check("R3 same-cycle out", pad_out, 16'hAA00);
        @(negedge clk);
        pad_in = 16'h0F0F;
        clocks(5);
        check("R4 gpio_din", gpio_din, 16'h0F0F);
        check("R4 periph_in", periph_in, 16'h000F);
        pad_in = 16'h0000;
        clocks(5);
    endtask

    task automatic t_write_timing;
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h0000);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 16'h00FF;
        #1;
        check("R5 before edge", pad_oe, 16'h0000);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        check("R5 after edge", pad_oe, 16'h00FF);
        for (int a = 5; a < 8; a++) wr(3'(a), 16'hFFFF);
        check("R5 unmapped oe", pad_oe, 16'h00FF);
        check("R5 unmapped out", pad_out, 16'hAAAA);
        pad_in = 16'h0001;
        clocks(4);
        check("R5 unmapped count stays 0", gpio_din, 16'h0001);
        pad_in = 16'h0000;
        clocks(4);
    endtask

    task automatic t_bypass;
        wr(3'd3, 16'h0000);
        clocks(4);
        pad_in[0] = 1'b1;
        @(posedge clk); @(negedge clk);
        pad_in[0] = 1'b0;
        check("R6 edge1", gpio_din, 16'h0000);
        clocks(1);
        check("R6 edge2", gpio_din, 16'h0000);
        clocks(1);
        check("R6 edge3", gpio_din, 16'h0001);
        clocks(1);
        check("R6 edge4", gpio_din, 16'h0000);
    endtask

    task automatic t_glitch;
        wr(3'd4, 16'h0000);
        wr(3'd3, 16'h0004);
        clocks(4);
        pad_in[0] = 1'b1;
        clocks(3);
        pad_in[0] = 1'b0;
        clocks(10);
        check("R7 3-sample pulse dropped", gpio_din, 16'h0000);
        pad_in[1] = 1'b1;
        clocks(1);
        pad_in[1] = 1'b0;
        clocks(10);
        check("R7 1-sample pulse dropped", gpio_din, 16'h0000);
        pad_in[0] = 1'b1;
        clocks(5);
        check("R8 not before edge 6", gpio_din, 16'h0000);
        clocks(1);
        check("R8 taken at edge 6", gpio_din, 16'h0001);
        pad_in[0] = 1'b0;
        clocks(3);
        pad_in[0] = 1'b1;
        clocks(10);
        check("R7 low glitch dropped", gpio_din, 16'h0001);
        pad_in[0] = 1'b0;
        clocks(10);
        check("R8 falling level taken", gpio_din, 16'h0000);
    endtask

    task automatic t_divider;
        wr(3'd4, 16'h0003);
        wr(3'd3, 16'h0002);
        clocks(8);
        pad_in[0] = 1'b1;
        clocks(3);
        pad_in[0] = 1'b0;
        clocks(20);
        check("R9 short pulse dropped", gpio_din, 16'h0000);
        pad_in[0] = 1'b1;
        clocks(6);
        check("R9 too early", gpio_din, 16'h0000);
        clocks(4);
        check("R9 within window", gpio_din, 16'h0001);
        pad_in[0] = 1'b0;
        clocks(20);
    endtask

    task automatic t_clear;
        pad_in[0] = 1'b1;
        for (int k = 0; k < 10; k++) begin
            wr(3'd3, 16'h0002);
            repeat (3) @(posedge clk);
        end
        @(negedge clk);
        check("R10 progress cleared", gpio_din, 16'h0000);
        clocks(20);
        check("R10 accepted after writes stop", gpio_din, 16'h0001);
        pad_in[0] = 1'b0;
        clocks(20);
    endtask

    task automatic t_unqualified;
        wr(3'd4, 16'h0000);
        wr(3'd3, 16'h000F);
        clocks(4);
        pad_in[12] = 1'b1;
        @(posedge clk); @(negedge clk);
        pad_in[12] = 1'b0;
        clocks(1);
        check("R11 pin12 edge2", gpio_din, 16'h0000);
        clocks(1);
        check("R11 pin12 edge3", gpio_din, 16'h1000);
        clocks(1);
        check("R11 pin12 edge4", gpio_din, 16'h0000);
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        clocks(1);
        t_reset();
        t_gpio();
        t_periph();
        t_write_timing();
        t_bypass();
        t_glitch();
        t_divider();
        t_clear();
        t_unqualified();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule